// File: doc/BRIEF.md
# Modulo-Scheduled Loop Branch Unit

This unit resolves the closing branch of a software-pipelined loop. Each cycle it may receive one decoded loop branch (a counted form that only counts down, a counted top or exit form, or a while top or exit form), the slot of the bundle the branch sits in, and the qualifying predicate. It keeps the loop counter, the epilog counter and the rotating register base as internal state, together with the rotating stage predicate, and in the same cycle it reports whether the branch is taken, whether the branch is illegal, and which of the four loop resources the branch writes.

A classifier sorts every request into one of eight cases: `CS_NONE` (no request or a reserved opcode), `CS_FAULT` (loop branch outside the legal slot), `CS_COUNT` (loop counter nonzero), `CS_CL_ZERO` (count-only form with the loop counter at zero), `CS_KERNEL` (while form with the predicate set), `CS_DRAIN` (epilog counter above one), `CS_LAST` (epilog counter equal to one) and `CS_IDLE` (epilog counter at zero). A resolver turns the case into the taken decision, the write strobes and the step controls; top forms branch in `CS_COUNT`, `CS_KERNEL` and `CS_DRAIN`, exit forms take the opposite sense, and the count-only form branches only in `CS_COUNT`. The state registers move at the clock edge that ends the request cycle. Two load ports let the loop setup code write the loop counter and the epilog counter.

Top module: `modsched_loopbr`

## Requirements
- R1: A synchronous reset clears the loop counter, epilog counter, rotating base and stage predicate; with no request, taken, fault and all four write strobes are 0.
- R2: A loop branch (opcodes 0 to 4) in a slot other than 2 raises fault, is not taken, asserts no write strobe and changes no state, whatever the predicate.
- R3: The count-only form (opcode 0) with a nonzero loop counter is taken and decrements it; with the loop counter at 0 it falls through and the counter stays 0; in both cases only the loop-counter strobe is asserted.
- R4: The counted top (opcode 1) and counted exit (opcode 2) forms with a nonzero loop counter decrement it, set the stage predicate to 1, decrement the rotating base and keep the epilog counter; the top form is taken and the exit form is not.
- R5: The counted forms with the loop counter at 0 follow the epilog-counter cases of R7 to R9 with the loop counter kept at 0 and the stage predicate cleared; their qualifying predicate has no effect.
- R6: The while top (opcode 3) and while exit (opcode 4) forms with the predicate set keep the epilog counter, clear the stage predicate and decrement the rotating base; the top form is taken and the exit form is not.
- R7: With the predicate clear (or a counted form at loop counter 0) and the epilog counter above 1, the epilog counter and rotating base each decrement, the stage predicate is cleared, the top form is taken and the exit form is not.
- R8: In that situation with the epilog counter equal to 1, the epilog counter drops to 0, the rotating base decrements, the stage predicate is cleared, the top form falls through and the exit form is taken.
- R9: In that situation with the epilog counter at 0, the epilog counter and rotating base keep their values, the stage predicate is cleared, the top form falls through and the exit form is taken.
- R10: Counted top and exit forms assert all four write strobes; while forms assert the epilog, base and predicate strobes but not the loop-counter strobe; this holds whether or not the branch is taken.
- R11: The rotating base is 7 bits and wraps from 0 to 127 when decremented.
- R12: Taken, fault and the strobes are valid in the request cycle; the state holds its value until the next rising clock edge and takes the new value there.
- R13: A load port sets its counter at the next edge when the branch in that cycle does not write the same counter; when it does, the branch update wins.
- R14: A request with the valid input low, or with opcode 5, 6 or 7, has no effect and raises no fault in any slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_valid | input | 1 | A loop branch is presented this cycle |
| br_op | input | 3 | Loop branch opcode (0 count-only, 1 counted top, 2 counted exit, 3 while top, 4 while exit) |
| br_slot | input | 2 | Bundle slot of the branch |
| br_qp | input | 1 | Qualifying predicate value |
| ld_lc_en | input | 1 | Load the loop counter |
| ld_lc_val | input | 64 | Value for the loop counter |
| ld_ec_en | input | 1 | Load the epilog counter |
| ld_ec_val | input | 6 | Value for the epilog counter |
| br_taken | output | 1 | Branch is taken |
| br_fault | output | 1 | Illegal-operation fault |
| lc_we | output | 1 | Loop counter write strobe |
| ec_we | output | 1 | Epilog counter write strobe |
| rrb_we | output | 1 | Rotating base write strobe |
| pr63_we | output | 1 | Stage predicate write strobe |
| pr63_wval | output | 1 | Value written to the stage predicate |
| lc_o | output | 64 | Loop counter |
| ec_o | output | 6 | Epilog counter |
| rrb_o | output | 7 | Rotating register base |
| pr63_o | output | 1 | Stage predicate |

## Verification
Taken, fault and the write strobes are combinational, so they are due in the request cycle itself: the bench drives each request on a falling edge and samples these results two nanoseconds later, before the next rising edge. The counters and the stage predicate have one register stage, so their new values are due one nanosecond after that rising edge, where the bench samples them; one scenario also samples the loop counter before the edge to confirm it has not moved early. Each directed task walks the counters through a known sequence, so every expected value, including the base wrapping past 0, is fixed by the requirements alone.

// File: rtl/modsched_pkg.sv
package modsched_pkg;

    localparam int LC_W_DEF    = 64;
    localparam int EC_W_DEF    = 6;
    localparam int RRB_W_DEF   = 7;
    localparam int SLOT_W_DEF  = 2;
    localparam int LEGAL_SLOT  = 2;

    typedef enum logic [2:0] {
        OP_CLOOP = 3'd0,
        OP_CTOP  = 3'd1,
        OP_CEXIT = 3'd2,
        OP_WTOP  = 3'd3,
        OP_WEXIT = 3'd4,
        OP_RSV5  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } br_op_e;

    typedef enum logic [2:0] {
        CS_NONE,
        CS_FAULT,
        CS_COUNT,
        CS_CL_ZERO,
        CS_KERNEL,
        CS_DRAIN,
        CS_LAST,
        CS_IDLE
    } lb_case_e;

endpackage

// File: rtl/lb_classify.sv
module lb_classify
    import modsched_pkg::*;
#(
    parameter int SLOT_W = SLOT_W_DEF
) (
    input  logic              valid_i,
    input  br_op_e            op_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              qp_i,
    input  logic              lc_zero_i,
    input  logic              ec_gt1_i,
    input  logic              ec_one_i,
    output lb_case_e          case_o
);

    localparam logic [SLOT_W-1:0] SLOT_OK = SLOT_W'(LEGAL_SLOT);

    lb_case_e ec_case;

    always_comb begin
        if (ec_gt1_i)      ec_case = CS_DRAIN;
        else if (ec_one_i) ec_case = CS_LAST;
        else               ec_case = CS_IDLE;
    end

    always_comb begin
        case_o = CS_NONE;
        if (valid_i) begin
            unique case (op_i)
                OP_CLOOP: begin
                    if (slot_i != SLOT_OK) case_o = CS_FAULT;
                    else                   case_o = lc_zero_i ? CS_CL_ZERO : CS_COUNT;
                end
                OP_CTOP, OP_CEXIT: begin
                    if (slot_i != SLOT_OK) case_o = CS_FAULT;
                    else                   case_o = lc_zero_i ? ec_case : CS_COUNT;
                end
                OP_WTOP, OP_WEXIT: begin
                    if (slot_i != SLOT_OK) case_o = CS_FAULT;
                    else                   case_o = qp_i ? CS_KERNEL : ec_case;
                end
                OP_RSV5, OP_RSV6, OP_RSV7: case_o = CS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lb_resolve.sv
module lb_resolve
    import modsched_pkg::*;
(
    input  lb_case_e case_i,
    input  br_op_e   op_i,
    output logic     taken_o,
    output logic     fault_o,
    output logic     lc_we_o,
    output logic     ec_we_o,
    output logic     rrb_we_o,
    output logic     pr_we_o,
    output logic     lc_dec_o,
    output logic     ec_dec_o,
    output logic     rrb_dec_o,
    output logic     pr_val_o
);

    logic is_exit;
    logic is_cloop;
    logic is_counted;

    assign is_exit    = (op_i == OP_CEXIT) || (op_i == OP_WEXIT);
    assign is_cloop   = (op_i == OP_CLOOP);
    assign is_counted = (op_i == OP_CTOP) || (op_i == OP_CEXIT);

    always_comb begin
        taken_o   = 1'b0;
        fault_o   = 1'b0;
        lc_we_o   = 1'b0;
        ec_we_o   = 1'b0;
        rrb_we_o  = 1'b0;
        pr_we_o   = 1'b0;
        lc_dec_o  = 1'b0;
        ec_dec_o  = 1'b0;
        rrb_dec_o = 1'b0;
        pr_val_o  = 1'b0;
        unique case (case_i)
            CS_NONE: ;
            CS_FAULT: fault_o = 1'b1;
            CS_COUNT: begin
                lc_we_o  = 1'b1;
                lc_dec_o = 1'b1;
                if (is_cloop) begin
                    taken_o = 1'b1;
                end else begin
                    ec_we_o   = 1'b1;
                    rrb_we_o  = 1'b1;
                    pr_we_o   = 1'b1;
                    rrb_dec_o = 1'b1;
                    pr_val_o  = 1'b1;
                    taken_o   = !is_exit;
                end
            end
            CS_CL_ZERO: lc_we_o = 1'b1;
            CS_KERNEL: begin
                ec_we_o   = 1'b1;
                rrb_we_o  = 1'b1;
                pr_we_o   = 1'b1;
                rrb_dec_o = 1'b1;
                taken_o   = !is_exit;
            end
            CS_DRAIN: begin
                lc_we_o   = is_counted;
                ec_we_o   = 1'b1;
                rrb_we_o  = 1'b1;
                pr_we_o   = 1'b1;
                ec_dec_o  = 1'b1;
                rrb_dec_o = 1'b1;
                taken_o   = !is_exit;
            end
            CS_LAST: begin
                lc_we_o   = is_counted;
                ec_we_o   = 1'b1;
                rrb_we_o  = 1'b1;
                pr_we_o   = 1'b1;
                ec_dec_o  = 1'b1;
                rrb_dec_o = 1'b1;
                taken_o   = is_exit;
            end
            CS_IDLE: begin
                lc_we_o  = is_counted;
                ec_we_o  = 1'b1;
                rrb_we_o = 1'b1;
                pr_we_o  = 1'b1;
                taken_o  = is_exit;
            end
        endcase
    end

endmodule

// File: rtl/lb_state.sv
module lb_state
    import modsched_pkg::*;
#(
    parameter int LC_W  = LC_W_DEF,
    parameter int EC_W  = EC_W_DEF,
    parameter int RRB_W = RRB_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lc_we_i,
    input  logic             ec_we_i,
    input  logic             rrb_we_i,
    input  logic             pr_we_i,
    input  logic             lc_dec_i,
    input  logic             ec_dec_i,
    input  logic             rrb_dec_i,
    input  logic             pr_val_i,
    input  logic             ld_lc_en_i,
    input  logic [LC_W-1:0]  ld_lc_val_i,
    input  logic             ld_ec_en_i,
    input  logic [EC_W-1:0]  ld_ec_val_i,
    output logic [LC_W-1:0]  lc_q,
    output logic [EC_W-1:0]  ec_q,
    output logic [RRB_W-1:0] rrb_q,
    output logic             pr_q
);

    logic [LC_W-1:0]  lc_d;
    logic [EC_W-1:0]  ec_d;
    logic [RRB_W-1:0] rrb_d;
    logic             pr_d;

    always_comb begin
        lc_d = lc_q;
        if (lc_we_i) begin
            if (lc_dec_i) lc_d = lc_q - LC_W'(1);
        end else if (ld_lc_en_i) begin
            lc_d = ld_lc_val_i;
        end

        ec_d = ec_q;
        if (ec_we_i) begin
            if (ec_dec_i) ec_d = ec_q - EC_W'(1);
        end else if (ld_ec_en_i) begin
            ec_d = ld_ec_val_i;
        end

        rrb_d = rrb_q;
        if (rrb_we_i && rrb_dec_i) rrb_d = rrb_q - RRB_W'(1);

        pr_d = pr_we_i ? pr_val_i : pr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lc_q  <= '0;
            ec_q  <= '0;
            rrb_q <= '0;
            pr_q  <= 1'b0;
        end else begin
            lc_q  <= lc_d;
            ec_q  <= ec_d;
            rrb_q <= rrb_d;
            pr_q  <= pr_d;
        end
    end

    AST_RRB_WRAP: assert property (@(posedge clk) disable iff (rst)
        (rrb_we_i && rrb_dec_i && rrb_q == '0) |=> (rrb_q == '1)); // R11

    AST_EC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (ec_we_i && ec_q == '0) |=> (ec_q == '0)); // R9

endmodule

// File: rtl/modsched_loopbr.sv
module modsched_loopbr
    import modsched_pkg::*;
#(
    parameter int LC_W   = LC_W_DEF,
    parameter int EC_W   = EC_W_DEF,
    parameter int RRB_W  = RRB_W_DEF,
    parameter int SLOT_W = SLOT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_valid,
    input  logic [2:0]        br_op,
    input  logic [SLOT_W-1:0] br_slot,
    input  logic              br_qp,
    input  logic              ld_lc_en,
    input  logic [LC_W-1:0]   ld_lc_val,
    input  logic              ld_ec_en,
    input  logic [EC_W-1:0]   ld_ec_val,
    output logic              br_taken,
    output logic              br_fault,
    output logic              lc_we,
    output logic              ec_we,
    output logic              rrb_we,
    output logic              pr63_we,
    output logic              pr63_wval,
    output logic [LC_W-1:0]   lc_o,
    output logic [EC_W-1:0]   ec_o,
    output logic [RRB_W-1:0]  rrb_o,
    output logic              pr63_o
);

    localparam logic [SLOT_W-1:0] SLOT_OK = SLOT_W'(LEGAL_SLOT);

    br_op_e   op;
    lb_case_e cs;
    logic     lc_dec, ec_dec, rrb_dec;

    assign op = br_op_e'(br_op);

    lb_classify #(.SLOT_W(SLOT_W)) u_classify (
        .valid_i   (br_valid),
        .op_i      (op),
        .slot_i    (br_slot),
        .qp_i      (br_qp),
        .lc_zero_i (lc_o == '0),
        .ec_gt1_i  (ec_o > EC_W'(1)),
        .ec_one_i  (ec_o == EC_W'(1)),
        .case_o    (cs)
    );

    lb_resolve u_resolve (
        .case_i    (cs),
        .op_i      (op),
        .taken_o   (br_taken),
        .fault_o   (br_fault),
        .lc_we_o   (lc_we),
        .ec_we_o   (ec_we),
        .rrb_we_o  (rrb_we),
        .pr_we_o   (pr63_we),
        .lc_dec_o  (lc_dec),
        .ec_dec_o  (ec_dec),
        .rrb_dec_o (rrb_dec),
        .pr_val_o  (pr63_wval)
    );

    lb_state #(.LC_W(LC_W), .EC_W(EC_W), .RRB_W(RRB_W)) u_state (
        .clk         (clk),
        .rst         (rst),
        .lc_we_i     (lc_we),
        .ec_we_i     (ec_we),
        .rrb_we_i    (rrb_we),
        .pr_we_i     (pr63_we),
        .lc_dec_i    (lc_dec),
        .ec_dec_i    (ec_dec),
        .rrb_dec_i   (rrb_dec),
        .pr_val_i    (pr63_wval),
        .ld_lc_en_i  (ld_lc_en),
        .ld_lc_val_i (ld_lc_val),
        .ld_ec_en_i  (ld_ec_en),
        .ld_ec_val_i (ld_ec_val),
        .lc_q        (lc_o),
        .ec_q        (ec_o),
        .rrb_q       (rrb_o),
        .pr_q        (pr63_o)
    );

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        br_fault |-> (!br_taken && !lc_we && !ec_we && !rrb_we && !pr63_we)); // R2

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (br_fault && !ld_lc_en && !ld_ec_en) |=>
            ($stable(lc_o) && $stable(ec_o) && $stable(rrb_o) && $stable(pr63_o))); // R2

    AST_KERNEL_ROTATES: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_slot == SLOT_OK && br_qp && (op == OP_WTOP || op == OP_WEXIT)) |=>
            (rrb_o == RRB_W'($past(rrb_o) - RRB_W'(1)) && ec_o == $past(ec_o) && !pr63_o)); // R6

    AST_LC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (lc_we && lc_o == '0) |=> (lc_o == '0)); // R3

    AST_CLOOP_LC_ONLY: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_slot == SLOT_OK && op == OP_CLOOP) |-> (!ec_we && !rrb_we && !pr63_we)); // R3

endmodule

// File: tb/test_modsched_loopbr.sv
`timescale 1ns/1ps
module test_modsched_loopbr;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid;
    logic [2:0]  br_op;
    logic [1:0]  br_slot;
    logic        br_qp;
    logic        ld_lc_en;
    logic [63:0] ld_lc_val;
    logic        ld_ec_en;
    logic [5:0]  ld_ec_val;
    logic        br_taken, br_fault, lc_we, ec_we, rrb_we, pr63_we, pr63_wval;
    logic [63:0] lc_o;
    logic [5:0]  ec_o;
    logic [6:0]  rrb_o;
    logic        pr63_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    modsched_loopbr i_modsched_loopbr (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_op(br_op), .br_slot(br_slot),
        .br_qp(br_qp), .ld_lc_en(ld_lc_en), .ld_lc_val(ld_lc_val), .ld_ec_en(ld_ec_en),
        .ld_ec_val(ld_ec_val), .br_taken(br_taken), .br_fault(br_fault), .lc_we(lc_we),
        .ec_we(ec_we), .rrb_we(rrb_we), .pr63_we(pr63_we), .pr63_wval(pr63_wval),
        .lc_o(lc_o), .ec_o(ec_o), .rrb_o(rrb_o), .pr63_o(pr63_o)
    );

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [63:0] lc, input logic [5:0] ec,
                             input logic [6:0] rrb, input logic pr);
        check(req, "lc", lc_o, lc);
        check(req, "ec", 64'(ec_o), 64'(ec));
        check(req, "rrb", 64'(rrb_o), 64'(rrb));
        check(req, "pr63", 64'(pr63_o), 64'(pr));
    endtask

    // drive one request, check same-cycle results, then pass the edge
    task automatic fire(input string req, input logic [2:0] op, input logic [1:0] slot,
                        input logic qp, input logic e_tk, input logic e_flt,
                        input logic [3:0] e_we);
        @(negedge clk);
        br_valid = 1'b1; br_op = op; br_slot = slot; br_qp = qp;
        #2;
        check(req, "taken", 64'(br_taken), 64'(e_tk));
        check(req, "fault", 64'(br_fault), 64'(e_flt));
        check(req, "strobes lc/ec/rrb/pr", 64'({lc_we, ec_we, rrb_we, pr63_we}), 64'(e_we));
        @(posedge clk);
        #1;
        br_valid = 1'b0;
    endtask

    task automatic load(input logic do_lc, input logic [63:0] lc, input logic do_ec,
                        input logic [5:0] ec);
        @(negedge clk);
        ld_lc_en = do_lc; ld_lc_val = lc; ld_ec_en = do_ec; ld_ec_val = ec;
        @(posedge clk);
        #1;
        ld_lc_en = 1'b0; ld_ec_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; br_valid = 1'b0; br_op = 3'd0; br_slot = 2'd0; br_qp = 1'b0;
        ld_lc_en = 1'b0; ld_lc_val = '0; ld_ec_en = 1'b0; ld_ec_val = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk_state("R1", 64'd0, 6'd0, 7'd0, 1'b0);
        check("R1", "idle outputs", 64'({br_taken, br_fault, lc_we, ec_we, rrb_we, pr63_we}), 64'd0);
    endtask

    task automatic t_cloop();
        load(1'b1, 64'd2, 1'b0, 6'd0);
        fire("R3", 3'd0, 2'd2, 1'b0, 1'b1, 1'b0, 4'b1000);
        chk_state("R3", 64'd1, 6'd0, 7'd0, 1'b0);
        fire("R3", 3'd0, 2'd2, 1'b1, 1'b1, 1'b0, 4'b1000);
        chk_state("R3", 64'd0, 6'd0, 7'd0, 1'b0);
        fire("R3", 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 4'b1000);
        chk_state("R3", 64'd0, 6'd0, 7'd0, 1'b0);
    endtask

    task automatic t_fault();
        load(1'b1, 64'd5, 1'b0, 6'd0);
        fire("R2", 3'd3, 2'd0, 1'b1, 1'b0, 1'b1, 4'b0000);
        chk_state("R2", 64'd5, 6'd0, 7'd0, 1'b0);
        fire("R2", 3'd0, 2'd1, 1'b0, 1'b0, 1'b1, 4'b0000);
        fire("R2", 3'd1, 2'd3, 1'b0, 1'b0, 1'b1, 4'b0000);
        chk_state("R2", 64'd5, 6'd0, 7'd0, 1'b0);
    endtask

    task automatic t_reserved();
        fire("R14", 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 4'b0000);
        fire("R14", 3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 4'b0000);
        chk_state("R14", 64'd5, 6'd0, 7'd0, 1'b0);
    endtask

    task automatic t_counted();
        load(1'b0, 64'd0, 1'b1, 6'd3);
        fire("R4 R10", 3'd1, 2'd2, 1'b0, 1'b1, 1'b0, 4'b1111);
        chk_state("R4 R11", 64'd4, 6'd3, 7'd127, 1'b1);
        fire("R4 R10", 3'd2, 2'd2, 1'b0, 1'b0, 1'b0, 4'b1111);
        chk_state("R4", 64'd3, 6'd3, 7'd126, 1'b1);
    endtask

    task automatic t_kernel();
        fire("R6 R10", 3'd3, 2'd2, 1'b1, 1'b1, 1'b0, 4'b0111);
        chk_state("R6", 64'd3, 6'd3, 7'd125, 1'b0);
        fire("R6", 3'd4, 2'd2, 1'b1, 1'b0, 1'b0, 4'b0111);
        chk_state("R6", 64'd3, 6'd3, 7'd124, 1'b0);
    endtask

    task automatic t_drain();
        fire("R7", 3'd3, 2'd2, 1'b0, 1'b1, 1'b0, 4'b0111);
        chk_state("R7", 64'd3, 6'd2, 7'd123, 1'b0);
        fire("R7", 3'd4, 2'd2, 1'b0, 1'b0, 1'b0, 4'b0111);
        chk_state("R7", 64'd3, 6'd1, 7'd122, 1'b0);
        fire("R8", 3'd3, 2'd2, 1'b0, 1'b0, 1'b0, 4'b0111);
        chk_state("R8", 64'd3, 6'd0, 7'd121, 1'b0);
        fire("R4", 3'd1, 2'd2, 1'b0, 1'b1, 1'b0, 4'b1111);
        chk_state("R4", 64'd2, 6'd0, 7'd120, 1'b1);
        fire("R9 R10", 3'd4, 2'd2, 1'b0, 1'b1, 1'b0, 4'b0111);
        chk_state("R9", 64'd2, 6'd0, 7'd120, 1'b0);
        fire("R9", 3'd3, 2'd2, 1'b0, 1'b0, 1'b0, 4'b0111);
        chk_state("R9", 64'd2, 6'd0, 7'd120, 1'b0);
    endtask

    task automatic t_counted_zero();
        load(1'b1, 64'd1, 1'b1, 6'd2);
        fire("R4", 3'd1, 2'd2, 1'b0, 1'b1, 1'b0, 4'b1111);
        chk_state("R4", 64'd0, 6'd2, 7'd119, 1'b1);
        fire("R5", 3'd1, 2'd2, 1'b1, 1'b1, 1'b0, 4'b1111);
        chk_state("R5", 64'd0, 6'd1, 7'd118, 1'b0);
        fire("R5 R8", 3'd2, 2'd2, 1'b1, 1'b1, 1'b0, 4'b1111);
        chk_state("R5", 64'd0, 6'd0, 7'd117, 1'b0);
        fire("R5 R9", 3'd2, 2'd2, 1'b0, 1'b1, 1'b0, 4'b1111);
        fire("R5 R9", 3'd1, 2'd2, 1'b1, 1'b0, 1'b0, 4'b1111);
        chk_state("R5", 64'd0, 6'd0, 7'd117, 1'b0);
    endtask

    task automatic t_priority();
        load(1'b1, 64'd3, 1'b0, 6'd0);
        @(negedge clk);
        br_valid = 1'b1; br_op = 3'd0; br_slot = 2'd2; br_qp = 1'b0;
        ld_lc_en = 1'b1; ld_lc_val = 64'd9; ld_ec_en = 1'b1; ld_ec_val = 6'd5;
        #2;
        check("R12", "lc before edge", lc_o, 64'd3);
        check("R12", "taken in request cycle", 64'(br_taken), 64'd1);
        @(posedge clk);
        #1;
        br_valid = 1'b0; ld_lc_en = 1'b0; ld_ec_en = 1'b0;
        check("R13", "branch wins lc", lc_o, 64'd2);
        check("R13", "load ec", 64'(ec_o), 64'd5);
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_cloop();
        t_fault();
        t_reserved();
        t_counted();
        t_kernel();
        t_drain();
        t_counted_zero();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule